// File: doc/BRIEF.md
# Pair ALU with Predicate Carry

This block is a 64-bit execution slice for three register-pair operations that exchange data with an 8-bit predicate. The first two are add-with-carry and subtract-with-borrow. Each takes its carry in from the predicate and writes its carry out back to the predicate. The third is an unsigned byte-lane minimum. It also reports, for each lane, whether the second operand's byte was the larger one.

A request is one cycle with `in_valid` high. It carries the two operands, the incoming predicate and a 2-bit opcode. Exactly one clock edge later the result and the predicate appear on registered outputs, and `out_valid` is high for that one cycle. The outputs keep their last values until the next request arrives.

Top module: `pair_alu_pcarry`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `result` and `pred_out` are all zero until the first request.
- R2: A request on cycle n produces `out_valid` high on cycle n+1 only. Cycles without a request leave `result` and `pred_out` unchanged.
- R3: Opcode 2'b00 (add-carry) gives `result` = A + B + cin, modulo 2^64.
- R4: The carry in cin is `pred_in` bit 0. Bits 7..1 of `pred_in` have no effect on any output.
- R5: Opcode 2'b01 (sub-carry) gives `result` = A + ~B + cin, modulo 2^64. With cin = 1 this is the exact difference A − B.
- R6: For opcodes 2'b00 and 2'b01, `pred_out` is the carry out of bit 63 copied into all eight bits, so it is either 8'hFF or 8'h00.
- R7: Opcode 2'b10 (byte minimum) treats A and B as eight unsigned bytes, lane i being bits 8i+7..8i. Result byte i is the smaller of the two lane-i bytes.
- R8: For opcode 2'b10, `pred_out` bit i is 1 exactly when B's lane-i byte is greater than A's lane-i byte.
- R9: Opcode 2'b11 gives `result` = 0 and `pred_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 2 | 00 add-carry, 01 sub-carry, 10 byte minimum, 11 zero |
| opnd_a | input | 64 | First operand A |
| opnd_b | input | 64 | Second operand B |
| pred_in | input | 8 | Incoming predicate; bit 0 is the carry in |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered 64-bit result |
| pred_out | output | 8 | Registered predicate |

## Verification
The add operation is tried with the all-ones operand plus one, which separates a correct carry out of bit 63 from a dropped one. It is also tried with carry-in 1 on small operands, which shows that cin is added. The subtract operation is tried with the minuend larger, and then smaller, than the subtrahend. This tells an exact difference that reports no borrow (carry 1) apart from a wrapped difference (carry 0). It also shows whether B is inverted or merely negated.

The byte minimum is tried with lanes mixing larger, smaller and equal bytes, including 8'h80 against 8'h7F. That pair exposes a signed compare and a swapped predicate direction. A predicate with only its upper bits set, and the reserved opcode, confirm that those inputs produce nothing beyond what R4 and R9 require.

// File: rtl/pair_alu_pkg.sv
package pair_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD_CARRY = 2'b00,
    OP_SUB_CARRY = 2'b01,
    OP_BYTE_MIN  = 2'b10,
    OP_ZERO      = 2'b11
  } alu_op_e;

endpackage

// File: rtl/pa_carry_adder.sv
// Full-width adder with optional inversion of the second operand
module pa_carry_adder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] add_a,
  input  logic [WIDTH-1:0] add_b,
  input  logic             invert_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    b_eff    = invert_b ? ~add_b : add_b;
    wide_sum = {1'b0, add_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, carry_in};
  end

  assign sum       = wide_sum[WIDTH-1:0];
  assign carry_out = wide_sum[WIDTH];

endmodule

// File: rtl/pa_lane_min.sv
// Per-lane unsigned minimum with a "second greater than first" flag
module pa_lane_min #(
  parameter int WIDTH  = 64,
  parameter int LANE_W = 8,
  localparam int LANES = WIDTH / LANE_W
) (
  input  logic [WIDTH-1:0] lane_a,
  input  logic [WIDTH-1:0] lane_b,
  output logic [WIDTH-1:0] lane_min,
  output logic [LANES-1:0] b_gt_a
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_byte;
    logic [LANE_W-1:0] b_byte;
    logic              gt;

    assign a_byte = lane_a[g*LANE_W +: LANE_W];
    assign b_byte = lane_b[g*LANE_W +: LANE_W];
    assign gt     = (b_byte > a_byte);

    assign b_gt_a[g]                    = gt;
    assign lane_min[g*LANE_W +: LANE_W] = gt ? a_byte : b_byte;
  end

endmodule

// File: rtl/pair_alu_pcarry.sv
module pair_alu_pcarry
  import pair_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int PRED_W = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        opcode,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [PRED_W-1:0] pred_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [PRED_W-1:0] pred_out
);

  alu_op_e           op;
  logic              cin;
  logic [PRED_W-2:0] unused_pred_hi;
  logic [DATA_W-1:0] add_sum;
  logic              add_cout;
  logic [DATA_W-1:0] min_val;
  logic [PRED_W-1:0] min_flags;

  logic [DATA_W-1:0] res_nxt;
  logic [PRED_W-1:0] pred_nxt;

  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic [PRED_W-1:0] pred_q;

  assign op             = alu_op_e'(opcode);
  assign cin            = pred_in[0];
  assign unused_pred_hi = pred_in[PRED_W-1:1];

  pa_carry_adder #(.WIDTH(DATA_W)) i_adder (
    .add_a     (opnd_a),
    .add_b     (opnd_b),
    .invert_b  (op == OP_SUB_CARRY),
    .carry_in  (cin),
    .sum       (add_sum),
    .carry_out (add_cout)
  );

  pa_lane_min #(.WIDTH(DATA_W), .LANE_W(LANE_W)) i_lane_min (
    .lane_a   (opnd_a),
    .lane_b   (opnd_b),
    .lane_min (min_val),
    .b_gt_a   (min_flags)
  );

  // next state
  always_comb begin
    res_nxt  = '0;
    pred_nxt = '0;
    case (op)
      OP_ADD_CARRY, OP_SUB_CARRY: begin
        res_nxt  = add_sum;
        pred_nxt = {PRED_W{add_cout}};
      end
      OP_BYTE_MIN: begin
        res_nxt  = min_val;
        pred_nxt = min_flags;
      end
      default: begin
        res_nxt  = '0;
        pred_nxt = '0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      pred_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_nxt;
        pred_q <= pred_nxt;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign pred_out  = pred_q;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(pred_out))); // R2
  AST_CIN_FROM_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b00 && opnd_a == '0 && opnd_b == '0)
      |=> (result == {{(DATA_W-1){1'b0}}, $past(pred_in[0])})); // R4
  AST_CARRY_FANOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !opcode[1]) |=> (pred_out == '0 || pred_out == '1)); // R6
  AST_EQUAL_LANES_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b10 && opnd_a == opnd_b)
      |=> (pred_out == '0 && result == $past(opnd_a))); // R8
  AST_ZERO_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 2'b11) |=> (result == '0 && pred_out == '0)); // R9

endmodule

// File: tb/test_pair_alu_pcarry.sv
module test_pair_alu_pcarry;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  opcode;
  logic [63:0] opnd_a;
  logic [63:0] opnd_b;
  logic [7:0]  pred_in;
  logic        out_valid;
  logic [63:0] result;
  logic [7:0]  pred_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pair_alu_pcarry i_pair_alu_pcarry (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .pred_in   (pred_in),
    .out_valid (out_valid),
    .result    (result),
    .pred_out  (pred_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // drive one request at a falling edge; results are sampled at the next falling edge
  task automatic issue(input logic [1:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] p);
    @(negedge clk);
    in_valid = 1'b1;
    opcode   = op;
    opnd_a   = a;
    opnd_b   = b;
    pred_in  = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [71:0] model_arith(input logic sub, input logic [63:0] a,
                                              input logic [63:0] b, input logic cin);
    logic [64:0] w;
    w = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {64'd0, cin};
    return {{8{w[64]}}, w[63:0]};
  endfunction

  function automatic logic [71:0] model_min(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    logic [7:0]  p;
    for (int i = 0; i < 8; i++) begin
      p[i]        = b[8*i +: 8] > a[8*i +: 8];
      r[8*i +: 8] = p[i] ? a[8*i +: 8] : b[8*i +: 8];
    end
    return {p, r};
  endfunction

  task automatic t_reset;
    chk("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1", "result", result, 64'd0);
    chk("R1", "pred_out", {56'd0, pred_out}, 64'd0);
  endtask

  task automatic t_add;
    logic [71:0] e;
    e = model_arith(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0);
    issue(2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 8'h00);
    chk("R2", "out_valid", {63'd0, out_valid}, 64'd1);
    chk("R3", "add wrap result", result, e[63:0]);
    chk("R6", "add carry fanout", {56'd0, pred_out}, {56'd0, e[71:64]});
    e = model_arith(1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 1'b1);
    issue(2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0000_0001_0000_0010, 8'h01);
    chk("R3", "add with cin", result, e[63:0]);
    chk("R6", "add no carry", {56'd0, pred_out}, 64'd0);
  endtask

  task automatic t_cin_lsb;
    issue(2'b00, 64'd100, 64'd23, 8'hFE);
    chk("R4", "upper pred bits ignored", result, 64'd123);
    chk("R4", "pred_out no carry", {56'd0, pred_out}, 64'd0);
    issue(2'b00, 64'd100, 64'd23, 8'h01);
    chk("R4", "lsb carry used", result, 64'd124);
  endtask

  task automatic t_sub;
    issue(2'b01, 64'd5, 64'd3, 8'h01);
    chk("R5", "exact difference", result, 64'd2);
    chk("R6", "no borrow -> all ones", {56'd0, pred_out}, 64'hFF);
    issue(2'b01, 64'd3, 64'd5, 8'h01);
    chk("R5", "wrapped difference", result, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R6", "borrow -> zero", {56'd0, pred_out}, 64'd0);
    issue(2'b01, 64'd5, 64'd3, 8'h00);
    chk("R5", "cin 0 subtract", result, 64'd1);
  endtask

  task automatic t_vmin;
    logic [71:0] e;
    logic [63:0] a;
    logic [63:0] b;
    a = 64'h80_10_FF_00_7F_33_01_AA;
    b = 64'h7F_20_FF_01_80_22_01_55;
    e = model_min(a, b);
    issue(2'b10, a, b, 8'hFF);
    chk("R7", "lane minimum", result, e[63:0]);
    chk("R8", "lane flags", {56'd0, pred_out}, {56'd0, e[71:64]});
    issue(2'b10, b, a, 8'h00);
    e = model_min(b, a);
    chk("R8", "swapped flags", {56'd0, pred_out}, {56'd0, e[71:64]});
  endtask

  task automatic t_zero_op;
    issue(2'b11, 64'hDEAD_BEEF_0000_0001, 64'h1, 8'h01);
    chk("R9", "zero opcode result", result, 64'd0);
    chk("R9", "zero opcode pred", {56'd0, pred_out}, 64'd0);
  endtask

  task automatic t_hold;
    issue(2'b00, 64'd7, 64'd8, 8'h00);
    @(negedge clk);
    opcode = 2'b11;
    opnd_a = 64'd99;
    @(negedge clk);
    chk("R2", "no valid after idle", {63'd0, out_valid}, 64'd0);
    chk("R2", "result held", result, 64'd15);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    opcode   = 2'b00;
    opnd_a   = '0;
    opnd_b   = '0;
    pred_in  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_cin_lsb();
    t_sub();
    t_vmin();
    t_zero_op();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule